// File: doc/BRIEF.md
# XOR Sprite Blitter with Collision Latch

This engine draws a rectangular sprite into a bit-per-pixel video memory built from three colour planes. The source bitmap is stored in the same memory. One start pulse launches a draw. Its inputs are a five-bit control field, a packed size code, an X and Y pixel position, and a source byte address. The engine then walks the sprite one column of eight pixels at a time and each column from its top row down. For each row it fetches a source byte and shifts it to the exact pixel offset. Because of the shift, the byte lands across two neighbouring destination bytes, and the engine XORs it into both. XOR lets the same call erase the sprite again later.

Each plane RAM is external and single-ported, with a one-cycle synchronous read. The engine shares one address bus across the three planes and gives each plane its own read and write strobes, so a plane can be masked out. When collision checking is on, the first row whose shifted source overlaps pixels already set latches a flag together with the column X and the row Y. No later overlap replaces them until the host clears the flag. `busy` stays high for the whole draw. A one-cycle `done` pulse ends it and carries a continue bit, which a command sequencer upstream can use.

Top module: `xor_sprite_blitter`

## Requirements
- R1: The size code gives the column count as 8 − size[7:5], which is 1 to 8 columns of 8 pixels. It gives the row count as 64 − 2·size[4:0], which is 2 to 64 rows.
- R2: Columns are drawn left to right and rows top to bottom. Every column starts again at the input Y, and the column X grows by 8 after each column. Y wraps modulo 2^YW and X wraps modulo 2^XW.
- R3: The source byte address starts at `src_addr` and steps by one for every row drawn. It is not reset between columns.
- R4: The destination byte is {0, y, x[XW-1:3]}, which is y·32 + x/8 for the default widths. The source byte is shifted right by s = x mod 8 and XORed into that byte. The source byte shifted left by 8 − s is XORed into the next byte, so with s = 0 the next byte keeps its value.
- R5: Control bits ctl[1], ctl[2] and ctl[3] enable planes 0, 1 and 2. A disabled plane gets no read strobe and no write strobe, and its contents stay unchanged.
- R6: Each row takes five cycles in a fixed order: read source, read destination byte, read next byte, write destination byte, write next byte. Each write therefore goes to the address read two cycles earlier, with nothing in between. Every enabled plane sees 3 reads and 2 writes per row.
- R7: Collision checking needs ctl[0] = 1 and the flag clear. A row collides when any enabled plane has a destination bit set that the shifted source also sets. The first such row sets `coll_flag` and latches `coll_x` as the column X and `coll_y` as the row Y. These values stay fixed while the flag is set.
- R8: `coll_clr` clears the flag on the next edge. It wins over a collision found in the same cycle.
- R9: `busy` is high for exactly 2 + cols·(1 + 5·rows) cycles. `done` is high only in the last of those cycles, and `cont` then equals ctl[4].
- R10: A start pulse that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `cont`, `coll_flag` and all memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled only when idle |
| ctl | input | 5 | [0] collision check, [3:1] plane enables, [4] continue |
| size | input | 8 | Packed size code: [7:5] column code, [4:0] row code |
| x_pos | input | XW | Starting pixel X |
| y_pos | input | YW | Starting pixel Y |
| src_addr | input | AW | Source byte address |
| coll_clr | input | 1 | Clears the collision flag |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| cont | output | 1 | Continue bit, valid with done |
| coll_flag | output | 1 | Collision pending |
| coll_x | output | XW | Column X of the first collision |
| coll_y | output | YW | Row Y of the first collision |
| mem_addr | output | AW | Shared plane RAM address |
| mem_rd_en | output | 3 | Per-plane read strobes |
| mem_wr_en | output | 3 | Per-plane write strobes |
| mem_wdata | output | 24 | Per-plane write bytes, plane p in [8p+7:8p] |
| mem_rdata | input | 24 | Per-plane read bytes, valid one cycle after a read strobe |

## Verification
The assertions rely on two things about the block's surroundings. Each plane RAM returns read data on the edge after the strobe and keeps it while no strobe is given. Nothing else drives the RAMs during a draw. The bench meets both by modelling the three planes as synchronous-read arrays that only the block's strobes touch, apart from bulk fills done while the engine is idle. Control inputs change only on the falling clock edge. `coll_clr` is never pulsed while a draw runs, so the flag history the bench predicts matches what the latch sees.

// File: rtl/xsb_pkg.sv
package xsb_pkg;
  localparam int BYTE_W = 8;            // pixels per plane byte
  localparam int SH_W   = 3;            // bits of sub-byte shift
  localparam int NPL    = 3;            // colour planes
  localparam int COLS_W = 4;            // holds 1..8
  localparam int ROWS_W = 7;            // holds 1..64

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_COL, ST_RSRC, ST_RD0, ST_RD1, ST_WR0, ST_WR1, ST_DONE
  } xsb_state_e;
endpackage

// File: rtl/xsb_lane.sv
module xsb_lane
  import xsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_src,
  input  logic              cap_d0,
  input  logic              cap_d1,
  input  logic [BYTE_W-1:0] rdata,
  input  logic [SH_W-1:0]   sh,
  output logic [BYTE_W-1:0] new0,
  output logic [BYTE_W-1:0] new1,
  output logic              overlap
);
  logic [BYTE_W-1:0]   src_q, d0_q, d1_q;
  logic [BYTE_W-1:0]   src_d, d0_d, d1_d;
  logic [2*BYTE_W-1:0] spread;

  always_comb begin
    src_d = cap_src ? rdata : src_q;
    d0_d  = cap_d0  ? rdata : d0_q;
    d1_d  = cap_d1  ? rdata : d1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else begin
      src_q <= src_d;
      d0_q  <= d0_d;
      d1_q  <= d1_d;
    end
  end

  // The source byte placed at the pixel offset, spread over two bytes.
  assign spread  = {src_q, {BYTE_W{1'b0}}} >> sh;
  assign new0    = d0_q ^ spread[2*BYTE_W-1:BYTE_W];
  assign new1    = d1_q ^ spread[BYTE_W-1:0];
  assign overlap = (|(d0_q & spread[2*BYTE_W-1:BYTE_W])) | (|(d1_q & spread[BYTE_W-1:0]));
endmodule

// File: rtl/xsb_coll.sv
module xsb_coll #(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          check,
  input  logic          hit,
  input  logic          clr,
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output logic          flag,
  output logic [XW-1:0] cx,
  output logic [YW-1:0] cy
);
  logic          flag_d;
  logic [XW-1:0] cx_d;
  logic [YW-1:0] cy_d;
  logic          take;

  assign take = check && hit && !flag && !clr;

  always_comb begin
    flag_d = flag;
    cx_d   = cx;
    cy_d   = cy;
    if (clr) begin
      flag_d = 1'b0;
    end else if (take) begin
      flag_d = 1'b1;
      cx_d   = x;
      cy_d   = y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      cx   <= '0;
      cy   <= '0;
    end else begin
      flag <= flag_d;
      cx   <= cx_d;
      cy   <= cy_d;
    end
  end

  a_r7_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> (flag && $stable(cx) && $stable(cy)));
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
endmodule

// File: rtl/xsb_seq.sv
module xsb_seq
  import xsb_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 8,
  parameter int AW = YW + XW - SH_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4:0]      ctl,
  input  logic [7:0]      size,
  input  logic [XW-1:0]   x_pos,
  input  logic [YW-1:0]   y_pos,
  input  logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   mem_addr,
  output logic [NPL-1:0]  rd_en,
  output logic [NPL-1:0]  wr_en,
  output logic [NPL-1:0]  plane_en,
  output logic            cap_src,
  output logic            cap_d0,
  output logic            cap_d1,
  output logic            second_wr,
  output logic            row_end,
  output logic            chk_en,
  output logic [SH_W-1:0] sh,
  output logic [XW-1:0]   col_x,
  output logic [YW-1:0]   row_y,
  output logic            busy,
  output logic            done,
  output logic            cont
);
  xsb_state_e        st, st_d;
  logic [NPL-1:0]    pe_q, pe_d;
  logic              chk_q, chk_d, cont_q, cont_d;
  logic [COLS_W-1:0] cols_left, cols_left_d;
  logic [ROWS_W-1:0] rows_tot, rows_tot_d, rows_left, rows_left_d;
  logic [XW-1:0]     cx_q, cx_d;
  logic [YW-1:0]     y0_q, y0_d, yc_q, yc_d;
  logic [AW-1:0]     src_q, src_d;
  logic [AW-1:0]     dst0, dst1;

  always_comb begin
    st_d        = st;
    pe_d        = pe_q;
    chk_d       = chk_q;
    cont_d      = cont_q;
    cols_left_d = cols_left;
    rows_tot_d  = rows_tot;
    rows_left_d = rows_left;
    cx_d        = cx_q;
    y0_d        = y0_q;
    yc_d        = yc_q;
    src_d       = src_q;
    case (st)
      ST_IDLE: if (start) begin
        st_d        = ST_SETUP;
        pe_d        = ctl[3:1];
        chk_d       = ctl[0];
        cont_d      = ctl[4];
        cols_left_d = COLS_W'(8) - COLS_W'(size[7:5]);
        rows_tot_d  = ROWS_W'(64) - ROWS_W'({size[4:0], 1'b0});
        cx_d        = x_pos;
        y0_d        = y_pos;
        src_d       = src_addr;
      end
      ST_SETUP: st_d = ST_COL;
      ST_COL: begin
        rows_left_d = rows_tot;
        yc_d        = y0_q;
        st_d        = ST_RSRC;
      end
      ST_RSRC: st_d = ST_RD0;
      ST_RD0:  st_d = ST_RD1;
      ST_RD1:  st_d = ST_WR0;
      ST_WR0:  st_d = ST_WR1;
      ST_WR1: begin
        yc_d        = yc_q + YW'(1);
        src_d       = src_q + AW'(1);
        rows_left_d = rows_left - ROWS_W'(1);
        if (rows_left != ROWS_W'(1)) begin
          st_d = ST_RSRC;
        end else if (cols_left == COLS_W'(1)) begin
          st_d = ST_DONE;
        end else begin
          cols_left_d = cols_left - COLS_W'(1);
          cx_d        = cx_q + XW'(8);
          st_d        = ST_COL;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pe_q      <= '0;
      chk_q     <= 1'b0;
      cont_q    <= 1'b0;
      cols_left <= '0;
      rows_tot  <= '0;
      rows_left <= '0;
      cx_q      <= '0;
      y0_q      <= '0;
      yc_q      <= '0;
      src_q     <= '0;
    end else begin
      st        <= st_d;
      pe_q      <= pe_d;
      chk_q     <= chk_d;
      cont_q    <= cont_d;
      cols_left <= cols_left_d;
      rows_tot  <= rows_tot_d;
      rows_left <= rows_left_d;
      cx_q      <= cx_d;
      y0_q      <= y0_d;
      yc_q      <= yc_d;
      src_q     <= src_d;
    end
  end

  assign dst0 = {1'b0, yc_q, cx_q[XW-1:SH_W]};
  assign dst1 = dst0 + AW'(1);

  always_comb begin
    case (st)
      ST_RSRC:        mem_addr = src_q;
      ST_RD0, ST_WR0: mem_addr = dst0;
      ST_RD1, ST_WR1: mem_addr = dst1;
      default:        mem_addr = '0;
    endcase
  end

  assign rd_en     = (st == ST_RSRC || st == ST_RD0 || st == ST_RD1) ? pe_q : '0;
  assign wr_en     = (st == ST_WR0 || st == ST_WR1) ? pe_q : '0;
  assign plane_en  = pe_q;
  assign cap_src   = (st == ST_RD0);
  assign cap_d0    = (st == ST_RD1);
  assign cap_d1    = (st == ST_WR0);
  assign second_wr = (st == ST_WR1);
  assign row_end   = (st == ST_WR1);
  assign chk_en    = chk_q;
  assign sh        = cx_q[SH_W-1:0];
  assign col_x     = cx_q;
  assign row_y     = yc_q;
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);
  assign cont      = done && cont_q;

  // R6: each write goes to the byte read two cycles before it
  a_r6_rmw_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR0) |-> (mem_addr == $past(mem_addr, 2)));
  a_r6_rmw_next: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR1) |-> (mem_addr == $past(mem_addr, 2)));
  a_r3_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR1) |=> (src_q == $past(src_q) + AW'(1)));
  a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COL && $past(st) == ST_WR1) |-> (cx_q == $past(cx_q) + XW'(8)));
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(rows_tot) && $stable(pe_q) && $stable(cont_q)));
  a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/xor_sprite_blitter.sv
module xor_sprite_blitter
  import xsb_pkg::*;
#(
  parameter  int XW = 8,
  parameter  int YW = 8,
  localparam int AW = YW + XW - SH_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [4:0]            ctl,
  input  logic [7:0]            size,
  input  logic [XW-1:0]         x_pos,
  input  logic [YW-1:0]         y_pos,
  input  logic [AW-1:0]         src_addr,
  input  logic                  coll_clr,
  output logic                  busy,
  output logic                  done,
  output logic                  cont,
  output logic                  coll_flag,
  output logic [XW-1:0]         coll_x,
  output logic [YW-1:0]         coll_y,
  output logic [AW-1:0]         mem_addr,
  output logic [NPL-1:0]        mem_rd_en,
  output logic [NPL-1:0]        mem_wr_en,
  output logic [NPL*BYTE_W-1:0] mem_wdata,
  input  logic [NPL*BYTE_W-1:0] mem_rdata
);
  logic [NPL-1:0]  plane_en, lane_hit;
  logic            cap_src, cap_d0, cap_d1, second_wr, row_end, chk_en;
  logic [SH_W-1:0] sh;
  logic [XW-1:0]   col_x;
  logic [YW-1:0]   row_y;

  xsb_seq #(.XW(XW), .YW(YW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .size(size),
    .x_pos(x_pos), .y_pos(y_pos), .src_addr(src_addr),
    .mem_addr(mem_addr), .rd_en(mem_rd_en), .wr_en(mem_wr_en), .plane_en(plane_en),
    .cap_src(cap_src), .cap_d0(cap_d0), .cap_d1(cap_d1), .second_wr(second_wr),
    .row_end(row_end), .chk_en(chk_en), .sh(sh), .col_x(col_x), .row_y(row_y),
    .busy(busy), .done(done), .cont(cont)
  );

  for (genvar p = 0; p < NPL; p++) begin : g_plane
    logic [BYTE_W-1:0] new0, new1;
    logic              ovl;
    xsb_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .cap_src(cap_src), .cap_d0(cap_d0), .cap_d1(cap_d1),
      .rdata(mem_rdata[p*BYTE_W +: BYTE_W]), .sh(sh),
      .new0(new0), .new1(new1), .overlap(ovl)
    );
    assign mem_wdata[p*BYTE_W +: BYTE_W] = second_wr ? new1 : new0;
    assign lane_hit[p] = ovl && plane_en[p];
  end

  xsb_coll #(.XW(XW), .YW(YW)) u_coll (
    .clk(clk), .rst_n(rst_n),
    .check(row_end && chk_en), .hit(|lane_hit), .clr(coll_clr),
    .x(col_x), .y(row_y),
    .flag(coll_flag), .cx(coll_x), .cy(coll_y)
  );

  a_r5_plane_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_en | mem_wr_en) & ~plane_en) == '0);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_rd_en == '0 && mem_wr_en == '0));
endmodule

// File: tb/xor_sprite_blitter_test.sv
module xor_sprite_blitter_test;
  localparam int YW = 4;
  localparam int XW = 8;
  localparam int AW = YW + XW - 3 + 1;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n, start, coll_clr;
  logic [4:0] ctl;
  logic [7:0] size;
  logic [XW-1:0] x_pos;
  logic [YW-1:0] y_pos;
  logic [AW-1:0] src_addr;
  logic busy, done, cont, coll_flag;
  logic [XW-1:0] coll_x;
  logic [YW-1:0] coll_y;
  logic [AW-1:0] mem_addr;
  logic [2:0] mem_rd_en, mem_wr_en;
  logic [23:0] mem_wdata, mem_rdata;

  xor_sprite_blitter #(.XW(XW), .YW(YW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl(ctl), .size(size),
    .x_pos(x_pos), .y_pos(y_pos), .src_addr(src_addr), .coll_clr(coll_clr),
    .busy(busy), .done(done), .cont(cont), .coll_flag(coll_flag),
    .coll_x(coll_x), .coll_y(coll_y), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] mem  [0:2][0:DEPTH-1];
  logic [7:0] refm [0:2][0:DEPTH-1];
  logic fill_req;
  int   fill_kind;
  int   checks = 0, failures = 0;

  function automatic logic [7:0] pat(int kind, int p, int a);
    logic [7:0] v;
    v = 8'((a * 29 + p * 71 + 13) ^ (a >> 2));
    if (kind == 0) return 8'h00;
    if (kind == 1) return (a < 256) ? (v | 8'h01) : 8'h00;
    return v;
  endfunction

  // Plane RAMs: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (fill_req) begin
      for (int p = 0; p < 3; p++)
        for (int a = 0; a < DEPTH; a++)
          mem[p][a] <= pat(fill_kind, p, a);
    end else begin
      for (int p = 0; p < 3; p++) begin
        if (mem_wr_en[p]) mem[p][mem_addr] <= mem_wdata[p*8 +: 8];
        if (mem_rd_en[p]) mem_rdata[p*8 +: 8] <= mem[p][mem_addr];
      end
    end
  end

  int nbusy, nrd[3], nwr[3];
  bit done_seen, got_cont;
  always @(negedge clk) begin
    if (busy) nbusy++;
    if (done) begin done_seen = 1'b1; got_cont = cont; end
    for (int p = 0; p < 3; p++) begin
      if (mem_rd_en[p]) nrd[p]++;
      if (mem_wr_en[p]) nwr[p]++;
    end
  end

  bit exp_flag;
  logic [7:0] exp_cx;
  logic [3:0] exp_cy;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int kind);
    @(negedge clk);
    fill_kind = kind;
    fill_req  = 1'b1;
    @(negedge clk);
    fill_req  = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_coll();
    @(negedge clk);
    coll_clr = 1'b1;
    @(negedge clk);
    coll_clr = 1'b0;
    check(coll_flag == 1'b0, "R8 flag after clear", int'(coll_flag), 0);
    exp_flag = 1'b0;
  endtask

  // Reference draw, computed from the requirements on a copy of memory
  task automatic model_op(input logic [4:0] c, input logic [7:0] sz,
                          input logic [7:0] x, input logic [3:0] y, input logic [9:0] i,
                          output int cols, output int rows);
    logic [7:0] cx;
    logic [3:0] yy;
    logic [9:0] s, d0, d1;
    logic [15:0] w;
    bit hit;
    cols = 8 - int'(sz[7:5]);
    rows = 64 - 2 * int'(sz[4:0]);
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < DEPTH; a++)
        refm[p][a] = mem[p][a];
    cx = x;
    s  = i;
    for (int k = 0; k < cols; k++) begin
      yy = y;
      for (int r = 0; r < rows; r++) begin
        d0 = {1'b0, yy, cx[7:3]};
        d1 = d0 + 10'd1;
        hit = 1'b0;
        for (int p = 0; p < 3; p++) begin
          if (c[1+p]) begin
            w = {refm[p][s], 8'h00} >> cx[2:0];
            if (((refm[p][d0] & w[15:8]) | (refm[p][d1] & w[7:0])) != 8'h00) hit = 1'b1;
            refm[p][d0] = refm[p][d0] ^ w[15:8];
            refm[p][d1] = refm[p][d1] ^ w[7:0];
          end
        end
        if (c[0] && !exp_flag && hit) begin
          exp_flag = 1'b1;
          exp_cx   = cx;
          exp_cy   = yy;
        end
        yy = yy + 4'd1;
        s  = s + 10'd1;
      end
      cx = cx + 8'd8;
    end
  endtask

  task automatic run_op(input logic [4:0] c, input logic [7:0] sz, input logic [7:0] x,
                        input logic [3:0] y, input logic [9:0] i, input bit bump,
                        input string tag);
    int cols, rows, bad, eb;
    model_op(c, sz, x, y, i, cols, rows);
    @(negedge clk);
    nbusy = 0; done_seen = 1'b0; got_cont = 1'b0;
    for (int p = 0; p < 3; p++) begin nrd[p] = 0; nwr[p] = 0; end
    ctl = c; size = sz; x_pos = x; y_pos = y; src_addr = i;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bump) begin
      repeat (4) @(negedge clk);
      ctl = 5'b11111; size = 8'h00; x_pos = 8'd0; y_pos = 4'd0; src_addr = 10'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    repeat (2) @(negedge clk);
    bad = 0;
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < DEPTH; a++)
        if (mem[p][a] !== refm[p][a]) bad++;
    check(bad == 0, {"R2/R3/R4/R5 image ", tag}, bad, 0);
    eb = 2 + cols * (1 + 5 * rows);
    check(nbusy == eb, {"R1/R9 busy length ", tag}, nbusy, eb);
    check(got_cont == c[4], {"R9 cont ", tag}, int'(got_cont), int'(c[4]));
    check(coll_flag == exp_flag && (!exp_flag || (coll_x == exp_cx && coll_y == exp_cy)),
          {"R7 collision ", tag},
          int'({coll_flag, coll_x, coll_y}), int'({exp_flag, exp_cx, exp_cy}));
    bad = 0;
    for (int p = 0; p < 3; p++) begin
      if (c[1+p]) begin
        if (nrd[p] != 3 * rows * cols || nwr[p] != 2 * rows * cols) bad++;
      end else if (nrd[p] != 0 || nwr[p] != 0) bad++;
    end
    check(bad == 0, {"R5/R6 strobe counts ", tag}, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; coll_clr = 1'b0; fill_req = 1'b0; fill_kind = 0;
    ctl = '0; size = '0; x_pos = '0; y_pos = '0; src_addr = '0;
    exp_flag = 1'b0; exp_cx = '0; exp_cy = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(busy == 0 && done == 0 && cont == 0, "R11 reset outputs", int'({busy, done, cont}), 0);
    check(coll_flag == 0 && mem_rd_en == 0 && mem_wr_en == 0, "R11 reset flag/strobes",
          int'({coll_flag, mem_rd_en, mem_wr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 every sub-byte shift, R2 X and Y wrap
    fill(1);
    for (int xs = 0; xs < 8; xs++)
      run_op({xs[0], 3'b111, 1'b1}, {3'd6, 5'd30}, 8'(24 * xs + xs),
             4'(9 + xs % 3), 10'(xs * 16), 1'b0, "shift");
    run_op(5'b01110, {3'd5, 5'd30}, 8'd250, 4'd13, 10'd100, 1'b0, "wrap");

    // R7 first collision kept, R8 clear
    clear_coll();
    fill(1);
    run_op(5'b01111, {3'd7, 5'd29}, 8'd35, 4'd10, 10'd40, 1'b0, "clean");
    run_op(5'b01111, {3'd7, 5'd29}, 8'd35, 4'd10, 10'd40, 1'b0, "redraw");
    run_op(5'b01111, {3'd6, 5'd30}, 8'd33, 4'd12, 10'd7, 1'b0, "second hit");
    clear_coll();

    // R1 every column code and several row codes, R5 plane masks, R3 across columns
    fill(2);
    for (int k = 0; k < 8; k++) begin
      clear_coll();
      run_op({k[0], 3'(k), 1'b1}, {3'(k), 5'(31 - k)}, 8'(k * 37), 4'(k * 5),
             10'(k * 101), 1'b0, "sweep");
    end
    clear_coll();
    run_op(5'b11110, 8'h00, 8'd3, 4'd0, 10'd900, 1'b0, "largest, check off");

    // R10 start while busy ignored
    run_op(5'b10101, {3'd6, 5'd28}, 8'd70, 4'd2, 10'd300, 1'b1, "R10 restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule